// File: doc/BRIEF.md
# Vector Split-Product Integer Multiplier

This block multiplies signed integers in several parallel lanes and returns each product exactly, without rounding. Each lane carries two operands as signed 64-bit words. Their magnitudes are expected to stay below 2^53. The full product is returned as a pair of signed 64-bit words (low, high) with product = low + 2^53 * high. The low word holds the bottom 53 bits of the product. The high word holds everything above them, sign-extended.

A per-vector mode bit selects an accumulating form. In that form the low result is added onto a supplied low accumulator word, and the high result onto a supplied high accumulator word. The two additions are independent and each wraps modulo 2^64.

Vectors enter through a valid/ready issue port and leave through a result port with valid and a downstream ready. The pipeline has a fixed depth of three stages. Its timing never depends on the operand values. A per-lane flag marks operands that fall outside the legal range.

Top module: `vmul_split`

## Requirements
- R1: After reset, out_valid is 0 and in_ready is 1.
- R2: With in_acc_mode=0, lane i (bits [64i+63:64i] of every lane bus) returns out_lo = the low 53 bits of the two's-complement product a*b, zero-extended to 64 bits. It returns out_hi = the product arithmetically shifted right by 53, as a signed 64-bit value.
- R3: R2 holds exactly for every sign combination and for the extreme operands +(2^53-1) and -(2^53-1).
- R4: With in_acc_mode=0, bits [63:53] of every out_lo lane are 0.
- R5: With in_acc_mode=1, out_lo = in_acc_lo + low and out_hi = in_acc_hi + high, per lane. Each sum wraps modulo 2^64, and there is no carry from the low sum into the high sum.
- R6: A vector accepted on clock edge n (in_valid and in_ready both high) appears with out_valid=1 right after edge n+2, provided out_ready stays high. This latency is the same for all operand values.
- R7: While out_ready is high, in_ready stays high, so one vector is accepted every cycle. Results leave in the order the vectors were accepted.
- R8: While out_valid=1 and out_ready=0, in_ready is 0, and out_lo, out_hi and out_oor hold their values.
- R9: out_oor[i] is 1 exactly when operand a or b of lane i lies outside -(2^53-1)..(2^53-1). Such a lane's data value is implementation-defined.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Issue request |
| in_ready | output | 1 | Pipeline can take a vector this cycle |
| in_acc_mode | input | 1 | 1 selects the accumulating form |
| in_a | input | 64*LANES | First operand per lane |
| in_b | input | 64*LANES | Second operand per lane |
| in_acc_lo | input | 64*LANES | Low accumulator per lane |
| in_acc_hi | input | 64*LANES | High accumulator per lane |
| out_valid | output | 1 | Result available |
| out_ready | input | 1 | Downstream takes the result |
| out_lo | output | 64*LANES | Low result word per lane |
| out_hi | output | 64*LANES | High result word per lane |
| out_oor | output | LANES | Per-lane out-of-range operand flag |

## Verification
The product is tried with small positive values, which exercise only the low word. Mixed signs show whether the high word sign-extends and whether the low word stays zero-extended. Extreme magnitudes fill both words completely, and one lane with a zero operand sits next to lanes with extreme operands. The accumulate form is driven with accumulators near the wrap points, which separates independent low/high additions from a joined 128-bit add. The latency is measured for zero operands and for extreme operands to show that it does not depend on data. Back-to-back issue and a held-off output check ordering, throughput and the stall hold. Operands just beyond the legal range check the flag.

// File: rtl/vmul_pkg.sv
package vmul_pkg;
  localparam int unsigned W     = 64;
  localparam int unsigned SPLIT = 53;
  localparam int unsigned PW    = W + SPLIT;
  localparam int unsigned DEPTH = 3;

  function automatic logic [PW-1:0] mul_full(input logic [W-1:0] a, input logic [W-1:0] b);
    logic signed [2*W-1:0] p;
    p = $signed({{W{a[W-1]}}, a}) * $signed({{W{b[W-1]}}, b});
    return p[PW-1:0];
  endfunction

  function automatic logic [W-1:0] lo_part(input logic [PW-1:0] p);
    return {{(W-SPLIT){1'b0}}, p[SPLIT-1:0]};
  endfunction

  function automatic logic [W-1:0] hi_part(input logic [PW-1:0] p);
    return p[PW-1:SPLIT];
  endfunction

  function automatic logic in_range(input logic [W-1:0] x);
    logic signed [W-1:0] lim;
    lim = (W'(1) << SPLIT) - W'(1);
    return ($signed(x) <= lim) && ($signed(x) >= -lim);
  endfunction
endpackage

// File: rtl/vmul_ctrl.sv
module vmul_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic in_valid,
  input  logic in_acc_mode,
  input  logic out_ready,
  output logic adv,
  output logic accept,
  output logic out_valid,
  output logic s2_mode,
  output logic s3_mode
);
  logic v1, v2, v3;
  logic m1, m2, m3;

  always_comb begin
    adv       = !v3 || out_ready;
    accept    = in_valid && adv;
    out_valid = v3;
    s2_mode   = m2;
    s3_mode   = m3;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      v1 <= 1'b0;
      v2 <= 1'b0;
      v3 <= 1'b0;
    end else if (adv) begin
      v1 <= in_valid;
      v2 <= v1;
      v3 <= v2;
    end
  end

  always_ff @(posedge clk) begin
    if (adv) begin
      m1 <= in_acc_mode;
      m2 <= m1;
      m3 <= m2;
    end
  end
endmodule

// File: rtl/vmul_lane.sv
module vmul_lane
  import vmul_pkg::*;
(
  input  logic         clk,
  input  logic         adv,
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic [W-1:0] acc_lo,
  input  logic [W-1:0] acc_hi,
  input  logic         mode_s2,
  output logic [W-1:0] lo,
  output logic [W-1:0] hi,
  output logic         oor
);
  logic [W-1:0]  a1, b1, al1, ah1;
  logic [W-1:0]  al2, ah2;
  logic [PW-1:0] p2;
  logic          oor2;
  logic [W-1:0]  add_lo, add_hi;

  always_comb begin
    add_lo = mode_s2 ? al2 : '0;
    add_hi = mode_s2 ? ah2 : '0;
  end

  always_ff @(posedge clk) begin
    if (adv) begin
      a1   <= a;
      b1   <= b;
      al1  <= acc_lo;
      ah1  <= acc_hi;
      p2   <= mul_full(a1, b1);
      oor2 <= !(in_range(a1) && in_range(b1));
      al2  <= al1;
      ah2  <= ah1;
      lo   <= lo_part(p2) + add_lo;
      hi   <= hi_part(p2) + add_hi;
      oor  <= oor2;
    end
  end
endmodule

// File: rtl/vmul_split.sv
module vmul_split #(
  parameter int unsigned LANES = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               in_valid,
  output logic               in_ready,
  input  logic               in_acc_mode,
  input  logic [64*LANES-1:0] in_a,
  input  logic [64*LANES-1:0] in_b,
  input  logic [64*LANES-1:0] in_acc_lo,
  input  logic [64*LANES-1:0] in_acc_hi,
  output logic               out_valid,
  input  logic               out_ready,
  output logic [64*LANES-1:0] out_lo,
  output logic [64*LANES-1:0] out_hi,
  output logic [LANES-1:0]   out_oor
);
  localparam int unsigned LW = vmul_pkg::W;

  logic adv, accept, fire, s2_mode, s3_mode;

  vmul_ctrl u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_valid   (in_valid),
    .in_acc_mode(in_acc_mode),
    .out_ready  (out_ready),
    .adv        (adv),
    .accept     (accept),
    .out_valid  (out_valid),
    .s2_mode    (s2_mode),
    .s3_mode    (s3_mode)
  );

  assign in_ready = adv;
  assign fire     = out_valid && out_ready;

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    vmul_lane u_lane (
      .clk    (clk),
      .adv    (adv),
      .a      (in_a[LW*i +: LW]),
      .b      (in_b[LW*i +: LW]),
      .acc_lo (in_acc_lo[LW*i +: LW]),
      .acc_hi (in_acc_hi[LW*i +: LW]),
      .mode_s2(s2_mode),
      .lo     (out_lo[LW*i +: LW]),
      .hi     (out_hi[LW*i +: LW]),
      .oor    (out_oor[i])
    );
  end
endmodule

// File: rtl/vmul_split_chk.sv
module vmul_split_chk #(
  parameter int unsigned LANES = 4
) (
  input logic               clk,
  input logic               rst_n,
  input logic               in_ready,
  input logic               out_valid,
  input logic               out_ready,
  input logic [64*LANES-1:0] out_lo,
  input logic [64*LANES-1:0] out_hi,
  input logic [LANES-1:0]   out_oor,
  input logic               adv,
  input logic               accept,
  input logic               fire,
  input logic               s3_mode
);
  logic       lo_top_clear;
  logic [2:0] inflight;

  always_comb begin
    lo_top_clear = 1'b1;
    for (int i = 0; i < LANES; i++)
      if (out_lo[64*i+53 +: 11] != 11'd0) lo_top_clear = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) inflight <= '0;
    else inflight <= inflight + 3'(accept) - 3'(fire);
  end

  // R4: plain form leaves the top of each low word clear
  assert_lo_zero_ext_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !s3_mode) |-> lo_top_clear);

  // R6: fixed three-stage latency when never stalled
  assert_fixed_latency_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(accept, 3) && $past(adv, 2) && $past(adv, 1)) |-> out_valid);

  // R8: held result and back-pressure while stalled
  assert_stall_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_lo) && $stable(out_hi) && $stable(out_oor)));

  assert_stall_block_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |-> !in_ready);

  // R7: never more vectors in flight than pipeline stages, none lost
  assert_inflight_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (inflight <= 3'(vmul_pkg::DEPTH)) && (!out_valid || inflight != 3'd0));
endmodule

bind vmul_split vmul_split_chk #(.LANES(LANES)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .in_ready (in_ready),
  .out_valid(out_valid),
  .out_ready(out_ready),
  .out_lo   (out_lo),
  .out_hi   (out_hi),
  .out_oor  (out_oor),
  .adv      (adv),
  .accept   (accept),
  .fire     (fire),
  .s3_mode  (s3_mode)
);

// File: tb/sim_vmul_split.sv
`timescale 1ns/1ps
module sim_vmul_split;
  localparam int L = 4;
  localparam int BW = 64*L;
  localparam longint MAXV = (64'sd1 <<< 53) - 64'sd1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0, in_acc_mode = 1'b0, out_ready = 1'b1;
  logic in_ready, out_valid;
  logic [BW-1:0] in_a = '0, in_b = '0, in_acc_lo = '0, in_acc_hi = '0;
  logic [BW-1:0] out_lo, out_hi;
  logic [L-1:0] out_oor;

  int checks = 0, fails = 0;
  bit done = 0;

  logic [BW-1:0] q_lo[$], q_hi[$];
  logic [L-1:0]  q_oor[$];
  bit            q_chk[$];
  string         q_tag[$];

  always #10 clk = ~clk;

  vmul_split #(.LANES(L)) u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_acc_mode(in_acc_mode), .in_a(in_a), .in_b(in_b),
    .in_acc_lo(in_acc_lo), .in_acc_hi(in_acc_hi), .out_valid(out_valid),
    .out_ready(out_ready), .out_lo(out_lo), .out_hi(out_hi), .out_oor(out_oor)
  );

  function automatic logic signed [127:0] prod(input logic [63:0] a, input logic [63:0] b);
    return $signed({{64{a[63]}}, a}) * $signed({{64{b[63]}}, b});
  endfunction

  function automatic logic [63:0] e_lo(input logic [63:0] a, input logic [63:0] b);
    logic signed [127:0] p;
    p = prod(a, b);
    return {11'd0, p[52:0]};
  endfunction

  function automatic logic [63:0] e_hi(input logic [63:0] a, input logic [63:0] b);
    logic signed [127:0] p, r, d, q;
    p = prod(a, b);
    r = $signed({75'd0, p[52:0]});
    d = 128'sd1 <<< 53;
    q = (p - r) / d;
    return q[63:0];
  endfunction

  function automatic bit e_oor(input logic [63:0] x);
    longint s;
    s = x;
    return (s > MAXV) || (s < -MAXV);
  endfunction

  function automatic logic [BW-1:0] pk(input longint v0, input longint v1, input longint v2, input longint v3);
    return {v3, v2, v1, v0};
  endfunction

  task automatic check(input bit ok, input string tag, input logic [BW-1:0] act, input logic [BW-1:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic send(input logic [BW-1:0] a, input logic [BW-1:0] b,
                      input logic [BW-1:0] al, input logic [BW-1:0] ah,
                      input logic m, input bit chk, input string tag, output int waits);
    logic [BW-1:0] xl, xh;
    logic [L-1:0] xo;
    in_a = a; in_b = b; in_acc_lo = al; in_acc_hi = ah; in_acc_mode = m;
    in_valid = 1'b1;
    waits = 0;
    while (!in_ready) begin
      @(negedge clk);
      waits++;
    end
    for (int i = 0; i < L; i++) begin
      xl[64*i +: 64] = e_lo(a[64*i +: 64], b[64*i +: 64]) + (m ? al[64*i +: 64] : 64'd0);
      xh[64*i +: 64] = e_hi(a[64*i +: 64], b[64*i +: 64]) + (m ? ah[64*i +: 64] : 64'd0);
      xo[i] = e_oor(a[64*i +: 64]) || e_oor(b[64*i +: 64]);
    end
    q_lo.push_back(xl); q_hi.push_back(xh); q_oor.push_back(xo);
    q_chk.push_back(chk); q_tag.push_back(tag);
    @(negedge clk);
  endtask

  task automatic drain();
    in_valid = 1'b0;
    out_ready = 1'b1;
    for (int k = 0; k < 40; k++) begin
      if (q_lo.size() == 0 && !out_valid) break;
      @(negedge clk);
    end
    check(q_lo.size() == 0, "R7 all results delivered", BW'(q_lo.size()), '0);
  endtask

  // Scoreboard: results must come out in acceptance order
  always @(negedge clk) begin
    if (rst_n && out_valid && out_ready) begin
      if (q_lo.size() == 0) begin
        check(1'b0, "R7 unexpected result", out_lo, '0);
      end else begin
        automatic logic [BW-1:0] xl = q_lo.pop_front();
        automatic logic [BW-1:0] xh = q_hi.pop_front();
        automatic logic [L-1:0]  xo = q_oor.pop_front();
        automatic bit c = q_chk.pop_front();
        automatic string t = q_tag.pop_front();
        if (c) begin
          check(out_lo === xl, {t, " low"}, out_lo, xl);
          check(out_hi === xh, {t, " high"}, out_hi, xh);
        end
        check(out_oor === xo, {t, " R9 oor"}, BW'(out_oor), BW'(xo));
      end
    end
  end

  task automatic t_reset();
    check(out_valid === 1'b0, "R1 out_valid after reset", BW'(out_valid), '0);
    check(in_ready === 1'b1, "R1 in_ready after reset", BW'(in_ready), BW'(1));
  endtask

  task automatic t_basic();
    int w;
    send(pk(3, 100, 0, 12345), pk(7, 200, 99, 1000), '0, '0, 0, 1, "R2 small", w);
    send(pk(-3, 5, -1, -(64'sd1 <<< 30)), pk(7, -9, -1, 64'sd1 <<< 30), '0, '0, 0, 1, "R3 mixed signs", w);
    drain();
  endtask

  task automatic t_extremes();
    int w;
    send(pk(MAXV, -MAXV, MAXV, -MAXV), pk(MAXV, MAXV, -MAXV, -MAXV), '0, '0, 0, 1, "R3 extremes", w);
    send(pk(MAXV, 0, 64'sd1 <<< 52, -(64'sd1 <<< 52)), pk(1, MAXV, 2, 2), '0, '0, 0, 1, "R3 boundary 2^53", w);
    drain();
  endtask

  task automatic t_acc();
    int w;
    send(pk(MAXV, 5, -7, 0), pk(MAXV, 6, 9, 0),
         pk(-1, 10, 64'sh7FFF_FFFF_FFFF_FFFF, 0),
         pk(64'sh7FFF_FFFF_FFFF_FFFF, -20, 3, -1), 1, 1, "R5 accumulate wrap", w);
    send(pk(-MAXV, 1, 2, 3), pk(MAXV, 1, 2, 3), pk(1, 2, 3, 4), pk(5, 6, 7, 8), 1, 1, "R5 accumulate", w);
    drain();
  endtask

  task automatic t_latency(input logic [BW-1:0] a, input logic [BW-1:0] b, input string tag);
    int w, n;
    out_ready = 1'b1;
    send(a, b, '0, '0, 0, 1, tag, w);
    in_valid = 1'b0;
    n = 0;
    while (!out_valid && n < 10) begin
      @(negedge clk);
      n++;
    end
    check(n == 2, tag, BW'(n), BW'(2));
    drain();
  endtask

  task automatic t_stream();
    int w, stalls;
    stalls = 0;
    out_ready = 1'b1;
    for (int k = 0; k < 8; k++) begin
      send(pk(k * 1000 - 3, -k, MAXV - k, k), pk(k + 1, MAXV, -k - 2, -MAXV), '0, '0,
           k[0], 1, "R7 stream", w);
      stalls += w;
    end
    check(stalls == 0, "R7 one vector per cycle", BW'(stalls), '0);
    drain();
  endtask

  task automatic t_stall();
    int w;
    logic [BW-1:0] hold_lo, hold_hi;
    out_ready = 1'b0;
    send(pk(11, 12, 13, 14), pk(2, 3, 4, 5), '0, '0, 0, 1, "R8 stalled a", w);
    send(pk(-MAXV, 1, 1, 1), pk(MAXV, 1, 1, 1), '0, '0, 0, 1, "R8 stalled b", w);
    send(pk(9, 9, 9, 9), pk(-9, 9, -9, 9), '0, '0, 0, 1, "R8 stalled c", w);
    in_valid = 1'b0;
    hold_lo = out_lo; hold_hi = out_hi;
    repeat (4) @(negedge clk);
    check(out_valid === 1'b1, "R8 valid held", BW'(out_valid), BW'(1));
    check(in_ready === 1'b0, "R8 in_ready low", BW'(in_ready), '0);
    check(out_lo === hold_lo && out_hi === hold_hi, "R8 data held", out_lo, hold_lo);
    drain();
  endtask

  task automatic t_oor();
    int w;
    send(pk(64'sd1 <<< 53, 5, -(64'sd1 <<< 53), MAXV), pk(3, -(MAXV + 1), 1, -MAXV),
         '0, '0, 0, 0, "R9 out of range", w);
    send(pk(64'sh7FFF_FFFF_FFFF_FFFF, 0, 1, 2), pk(1, 64'sh8000_0000_0000_0000, 1, 2),
         '0, '0, 0, 0, "R9 far out of range", w);
    drain();
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  initial begin
    #2_000_000;
    fails++;
    checks++;
    $display("FAIL watchdog expired actual=running expected=finished");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_basic();
    t_extremes();
    t_acc();
    t_latency('0, '0, "R6 latency zero operands");
    t_latency(pk(MAXV, -MAXV, MAXV, -1), pk(-MAXV, -MAXV, MAXV, MAXV), "R6 latency extreme operands");
    t_stream();
    t_stall();
    t_oor();
    finish_run();
  end
endmodule